// File: doc/BRIEF.md
# Filtered Window Hasher

This block takes a payload stream delivered four bytes per clock and strips out bytes that carry no content: null, horizontal tab and line feed. The bytes that survive are packed in arrival order into a rolling ten-byte window. Each surviving byte moves the window forward by one position. For every window position produced this way, the block emits a keyed hash. A word can therefore yield anywhere from zero to four hashes in one clock.

Each hash bit is the XOR of a subset of the 80 window bits. The subset is selected by one row of a mask table that software loads through a row-write port. The output lanes carry the hash, the matching 80-bit window and a valid flag. A downstream counting stage can use them to look for content that repeats often. A start-of-packet flag restarts the fill count, so no window spans two packets.

Top module: `filtered_window_hasher`

## Requirements
- R1: After reset every `out_valid` bit is 0 and every mask row is zero, so a full window hashed before its row is written gives 0 in that bit.
- R2: Bytes 0x00, 0x09 and 0x0A are dropped and never enter the window. All other byte values are kept.
- R3: Byte lane j of `in_data` is bits [8j+7:8j], and lane 0 is the oldest. In every output window, bits [7:0] hold the newest byte and bits [79:72] hold the oldest.
- R4: The window advances by exactly the number of kept bytes in the word. Output lane j carries the window that ends at the (j+1)-th kept byte of that word, and `out_valid[j]` can be 1 only when j is less than that count.
- R5: A window is valid only once at least 10 kept bytes have arrived since reset or since the most recent word with `in_sop` set. The bytes of that word are counted from zero.
- R6: Hash bit i of a valid lane equals the XOR over all window bits whose matching bit in mask row i is 1.
- R7: A word sampled at a rising edge E appears on the outputs after edge E+2. Until then the outputs show the result of the previous word.
- R8: A mask row written at edge W is used for the outputs registered at edge W+1 and later. The outputs registered at edge W still use the old row.
- R9: A write whose row number is at least HASH_W (rows 12 to 15 at the default sizes) changes no mask row.
- R10: A word with `in_valid` low adds no byte to the window, does not change the fill count and produces no valid lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | The input word is present |
| in_sop | input | 1 | The word starts a new packet |
| in_data | input | LANES*8 | Payload bytes, lane 0 oldest |
| cfg_wr_en | input | 1 | Mask row write strobe |
| cfg_wr_row | input | ROW_AW | Mask row to write |
| cfg_wr_mask | input | WIN_BYTES*8 | New mask row contents |
| out_valid | output | LANES | Per-lane hash valid |
| out_hash | output | LANES*HASH_W | Per-lane hash, lane j at [j*HASH_W +: HASH_W] |
| out_win | output | LANES*WIN_BYTES*8 | Per-lane window, lane j at [j*80 +: 80] |

## Verification
On every cycle, the assertions check the following:
- A dropped byte never sets its keep flag, and an idle word keeps nothing.
- The number of windows never exceeds the number of kept bytes.
- Adjacent valid lanes hold windows that differ by exactly a one-byte shift.
- The fill count stays bounded, and a start-of-packet word yields no valid window.
- Valid flags emerge exactly one stage later.
- Writes to rows that do not exist leave the mask table untouched.

The bench scenarios show what no single-cycle property can express:
- The exact byte content of each window.
- The hash values produced by a loaded key.
- The precise edge at which a rewritten mask row takes effect.
- The restart of window filling after a packet boundary in the middle of the stream.

// File: rtl/fwh_pkg.sv
package fwh_pkg;
   localparam int BYTE_W = 8;

   // Bytes treated as carrying no content: null, tab, line feed.
   function automatic logic byte_dropped(input logic [BYTE_W-1:0] b);
      return (b == 8'h00) || (b == 8'h09) || (b == 8'h0A);
   endfunction
endpackage

// File: rtl/fwh_char_filter.sv
module fwh_char_filter
   import fwh_pkg::*;
#(
   parameter int LANES = 4,
   localparam int DATA_W = LANES * BYTE_W
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_sop,
   input  logic [DATA_W-1:0] in_data,
   output logic [LANES-1:0]  keep_q,
   output logic [DATA_W-1:0] data_q,
   output logic              sop_q
);
   logic [LANES-1:0] keep_d;

   always_comb begin
      for (int j = 0; j < LANES; j++)
         keep_d[j] = in_valid && !byte_dropped(in_data[j*BYTE_W +: BYTE_W]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         keep_q <= '0;
         data_q <= '0;
         sop_q  <= 1'b0;
      end else begin
         keep_q <= keep_d;
         data_q <= in_data;
         sop_q  <= in_valid && in_sop;
      end
   end

   for (genvar gj = 0; gj < LANES; gj++) begin : g_lane_chk
      assert_drop_bytes_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && byte_dropped(in_data[gj*BYTE_W +: BYTE_W])) |=> !keep_q[gj]);
   end

   assert_idle_word_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (keep_q == '0) && !sop_q);
endmodule

// File: rtl/fwh_window_packer.sv
module fwh_window_packer
   import fwh_pkg::*;
#(
   parameter int LANES     = 4,
   parameter int WIN_BYTES = 10,
   localparam int DATA_W     = LANES * BYTE_W,
   localparam int WIN_W      = WIN_BYTES * BYTE_W,
   localparam int HIST_BYTES = WIN_BYTES + LANES - 1,
   localparam int HIST_W     = HIST_BYTES * BYTE_W,
   localparam int FILL_W     = $clog2(WIN_BYTES + 1)
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [LANES-1:0]       keep,
   input  logic [DATA_W-1:0]      data,
   input  logic                   sop,
   output logic [LANES*WIN_W-1:0] win_q,
   output logic [LANES-1:0]       win_vld_q
);
   logic [HIST_W-1:0]      hist_q, hist_d;
   logic [FILL_W-1:0]      fill_q, fill_d;
   logic [BYTE_W-1:0]      fresh [LANES];
   logic [HIST_W-1:0]      shifted [LANES+1];
   logic [WIN_W-1:0]       pick [LANES][LANES+1];
   logic [LANES*WIN_W-1:0] win_d;
   logic [LANES-1:0]       vld_d;
   int                     n_new;

   // Pack the kept bytes into slots 0.. in arrival order.
   always_comb begin
      int pos;
      pos = 0;
      for (int s = 0; s < LANES; s++) fresh[s] = '0;
      for (int j = 0; j < LANES; j++) begin
         for (int s = 0; s < LANES; s++)
            if (keep[j] && pos == s) fresh[s] = data[j*BYTE_W +: BYTE_W];
         pos = pos + int'(keep[j]);
      end
      n_new = pos;
   end

   // One candidate history per possible shift amount; byte 0 is newest.
   for (genvar gs = 0; gs <= LANES; gs++) begin : g_shift
      for (genvar gk = 0; gk < HIST_BYTES; gk++) begin : g_byte
         if (gk < gs) begin : g_new
            assign shifted[gs][gk*BYTE_W +: BYTE_W] = fresh[gs-1-gk];
         end else begin : g_old
            assign shifted[gs][gk*BYTE_W +: BYTE_W] = hist_q[(gk-gs)*BYTE_W +: BYTE_W];
         end
      end
   end

   always_comb begin
      hist_d = hist_q;
      for (int s = 0; s <= LANES; s++)
         if (n_new == s) hist_d = shifted[s];
   end

   // Window ending at the (j+1)-th kept byte, when s bytes were kept.
   for (genvar gj = 0; gj < LANES; gj++) begin : g_win
      for (genvar gs = 0; gs <= LANES; gs++) begin : g_cnt
         if (gs > gj) begin : g_real
            for (genvar gb = 0; gb < WIN_BYTES; gb++) begin : g_b
               assign pick[gj][gs][gb*BYTE_W +: BYTE_W] =
                  hist_d[(gs-1-gj+gb)*BYTE_W +: BYTE_W];
            end
         end else begin : g_none
            assign pick[gj][gs] = '0;
         end
      end
   end

   always_comb begin
      int base;
      base = sop ? 0 : int'(fill_q);
      for (int j = 0; j < LANES; j++) begin
         win_d[j*WIN_W +: WIN_W] = '0;
         for (int s = 0; s <= LANES; s++)
            if (n_new == s) win_d[j*WIN_W +: WIN_W] = pick[j][s];
         vld_d[j] = (j < n_new) && (base + j + 1 >= WIN_BYTES);
      end
      fill_d = (base + n_new >= WIN_BYTES) ? FILL_W'(WIN_BYTES) : FILL_W'(base + n_new);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q    <= '0;
         fill_q    <= '0;
         win_q     <= '0;
         win_vld_q <= '0;
      end else begin
         hist_q    <= hist_d;
         fill_q    <= fill_d;
         win_q     <= win_d;
         win_vld_q <= vld_d;
      end
   end

   assert_fill_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fill_q <= FILL_W'(WIN_BYTES));

   assert_sop_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
      sop |=> (win_vld_q == '0));

   assert_window_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ($countones(win_vld_q) <= $countones($past(keep))));

   for (genvar gj = 0; gj + 1 < LANES; gj++) begin : g_adj_chk
      assert_one_byte_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (win_vld_q[gj] && win_vld_q[gj+1]) |->
         (win_q[(gj+1)*WIN_W + BYTE_W +: WIN_W-BYTE_W] == win_q[gj*WIN_W +: WIN_W-BYTE_W]));
   end
endmodule

// File: rtl/fwh_mask_bank.sv
module fwh_mask_bank #(
   parameter int HASH_W = 12,
   parameter int WIN_W  = 80,
   localparam int ROW_AW = (HASH_W > 1) ? $clog2(HASH_W) : 1
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic [ROW_AW-1:0]       wr_row,
   input  logic [WIN_W-1:0]        wr_mask,
   output logic [HASH_W*WIN_W-1:0] masks
);
   for (genvar gr = 0; gr < HASH_W; gr++) begin : g_row
      logic [WIN_W-1:0] row_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            row_q <= '0;
         else if (wr_en && wr_row == ROW_AW'(gr))
            row_q <= wr_mask;
      end
      assign masks[gr*WIN_W +: WIN_W] = row_q;
   end

   // Only a row count short of a power of two leaves decodes with no row.
   if ((2 ** ROW_AW) > HASH_W) begin : g_sparse_rows
      assert_no_phantom_row_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && int'(wr_row) >= HASH_W) |=> $stable(masks));
   end

   assert_hold_without_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(masks));
endmodule

// File: rtl/fwh_xor_hash.sv
module fwh_xor_hash #(
   parameter int LANES  = 4,
   parameter int WIN_W  = 80,
   parameter int HASH_W = 12
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [LANES*WIN_W-1:0]  win,
   input  logic [LANES-1:0]        win_vld,
   input  logic [HASH_W*WIN_W-1:0] masks,
   output logic [LANES-1:0]        out_valid,
   output logic [LANES*HASH_W-1:0] out_hash,
   output logic [LANES*WIN_W-1:0]  out_win
);
   logic [LANES*HASH_W-1:0] hash_d;

   for (genvar gj = 0; gj < LANES; gj++) begin : g_lane
      for (genvar gi = 0; gi < HASH_W; gi++) begin : g_bit
         assign hash_d[gj*HASH_W + gi] =
            ^(masks[gi*WIN_W +: WIN_W] & win[gj*WIN_W +: WIN_W]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= '0;
         out_hash  <= '0;
         out_win   <= '0;
      end else begin
         out_valid <= win_vld;
         out_hash  <= hash_d;
         out_win   <= win;
      end
   end

   assert_stage_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (out_valid == $past(win_vld)));

   assert_zero_key_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (masks == '0) |=> (out_hash == '0));
endmodule

// File: rtl/filtered_window_hasher.sv
module filtered_window_hasher
   import fwh_pkg::*;
#(
   parameter int LANES     = 4,
   parameter int WIN_BYTES = 10,
   parameter int HASH_W    = 12,
   localparam int DATA_W = LANES * BYTE_W,
   localparam int WIN_W  = WIN_BYTES * BYTE_W,
   localparam int ROW_AW = (HASH_W > 1) ? $clog2(HASH_W) : 1
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   input  logic                    in_sop,
   input  logic [DATA_W-1:0]       in_data,
   input  logic                    cfg_wr_en,
   input  logic [ROW_AW-1:0]       cfg_wr_row,
   input  logic [WIN_W-1:0]        cfg_wr_mask,
   output logic [LANES-1:0]        out_valid,
   output logic [LANES*HASH_W-1:0] out_hash,
   output logic [LANES*WIN_W-1:0]  out_win
);
   if (LANES < 1 || WIN_BYTES <= LANES || HASH_W < 1) begin : g_bad_cfg
      $error("filtered_window_hasher: need LANES >= 1, WIN_BYTES > LANES, HASH_W >= 1");
   end

   logic [LANES-1:0]        keep_q;
   logic [DATA_W-1:0]       data_q;
   logic                    sop_q;
   logic [LANES*WIN_W-1:0]  win_q;
   logic [LANES-1:0]        win_vld_q;
   logic [HASH_W*WIN_W-1:0] masks;

   fwh_char_filter #(.LANES(LANES)) u_filter (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_sop   (in_sop),
      .in_data  (in_data),
      .keep_q   (keep_q),
      .data_q   (data_q),
      .sop_q    (sop_q)
   );

   fwh_window_packer #(.LANES(LANES), .WIN_BYTES(WIN_BYTES)) u_packer (
      .clk       (clk),
      .rst_n     (rst_n),
      .keep      (keep_q),
      .data      (data_q),
      .sop       (sop_q),
      .win_q     (win_q),
      .win_vld_q (win_vld_q)
   );

   fwh_mask_bank #(.HASH_W(HASH_W), .WIN_W(WIN_W)) u_masks (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cfg_wr_en),
      .wr_row  (cfg_wr_row),
      .wr_mask (cfg_wr_mask),
      .masks   (masks)
   );

   fwh_xor_hash #(.LANES(LANES), .WIN_W(WIN_W), .HASH_W(HASH_W)) u_hash (
      .clk       (clk),
      .rst_n     (rst_n),
      .win       (win_q),
      .win_vld   (win_vld_q),
      .masks     (masks),
      .out_valid (out_valid),
      .out_hash  (out_hash),
      .out_win   (out_win)
   );

   assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (out_valid == '0));
endmodule

// File: tb/tb_filtered_window_hasher.sv
module tb_filtered_window_hasher;
   localparam int CLK_PERIOD = 10;
   localparam int LANES  = 4;
   localparam int WINB   = 10;
   localparam int HASH_W = 12;
   localparam int WIN_W  = WINB * 8;
   localparam int ROW_AW = $clog2(HASH_W);

   typedef struct packed {
      logic        v;
      logic        sop;
      logic [31:0] d;
      logic [3:0]  m;
   } vec_t;

   localparam int NVEC = 14;
   localparam vec_t TBL [NVEC] = '{
      '{1'b1, 1'b1, 32'h64636261, 4'h0},   // abcd, packet start
      '{1'b1, 1'b0, 32'h0A660065, 4'h0},   // e . f . (two dropped)
      '{1'b0, 1'b0, 32'h6A696867, 4'h0},   // idle word, R10
      '{1'b1, 1'b0, 32'h6A696867, 4'h8},   // ghij, tenth byte in lane 3
      '{1'b1, 1'b0, 32'h6D6C096B, 4'h7},   // k . l m
      '{1'b1, 1'b0, 32'h0A09000A, 4'h0},   // all dropped
      '{1'b1, 1'b0, 32'h51504F4E, 4'hF},   // NOPQ
      '{1'b1, 1'b1, 32'h75747372, 4'h0},   // rstu, new packet
      '{1'b1, 1'b0, 32'h79787776, 4'h0},   // vwxy
      '{1'b1, 1'b0, 32'h3231007A, 4'h6},   // z . 1 2
      '{1'b1, 1'b1, 32'h42410000, 4'h0},   // . . A B, new packet
      '{1'b1, 1'b0, 32'h46454443, 4'h0},   // CDEF
      '{1'b1, 1'b0, 32'h4A494847, 4'h8},   // GHIJ
      '{1'b1, 1'b0, 32'h4E4D4C4B, 4'hF}    // KLMN
   };

   logic                    clk = 1'b0;
   logic                    rst_n = 1'b0;
   logic                    in_valid = 1'b0;
   logic                    in_sop = 1'b0;
   logic [31:0]             in_data = '0;
   logic                    cfg_wr_en = 1'b0;
   logic [ROW_AW-1:0]       cfg_wr_row = '0;
   logic [WIN_W-1:0]        cfg_wr_mask = '0;
   logic [LANES-1:0]        out_valid;
   logic [LANES*HASH_W-1:0] out_hash;
   logic [LANES*WIN_W-1:0]  out_win;

   int n_checks = 0;
   int n_fails  = 0;
   bit done     = 1'b0;

   logic [7:0]       mh [10];
   int               mcnt = 0;
   logic [WIN_W-1:0] mmask [HASH_W];
   logic [WIN_W-1:0] exp_win [LANES];
   logic [LANES-1:0] exp_v;

   filtered_window_hasher #(.LANES(LANES), .WIN_BYTES(WINB), .HASH_W(HASH_W)) dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data),
      .cfg_wr_en(cfg_wr_en), .cfg_wr_row(cfg_wr_row), .cfg_wr_mask(cfg_wr_mask),
      .out_valid(out_valid), .out_hash(out_hash), .out_win(out_win)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string req, input logic [WIN_W-1:0] act, input logic [WIN_W-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [WIN_W-1:0] key_row(input int i);
      logic [WIN_W-1:0] m;
      for (int b = 0; b < WIN_W; b++) m[b] = (((b * 7) + (i * 13) + ((b * b) % 11)) % 3) == 0;
      return m;
   endfunction

   function automatic logic [HASH_W-1:0] ref_hash(input logic [WIN_W-1:0] w);
      logic [HASH_W-1:0] h;
      for (int i = 0; i < HASH_W; i++) h[i] = ^(mmask[i] & w);
      return h;
   endfunction

   // Reference model built from R2..R5 and R10.
   task automatic model_word(input logic v, input logic sop, input logic [31:0] d);
      int base;
      int n;
      exp_v = '0;
      for (int j = 0; j < LANES; j++) exp_win[j] = '0;
      if (!v) return;
      base = sop ? 0 : mcnt;
      n = 0;
      for (int j = 0; j < LANES; j++) begin
         logic [7:0] b;
         b = d[j*8 +: 8];
         if (b != 8'h00 && b != 8'h09 && b != 8'h0A) begin
            for (int k = 9; k > 0; k--) mh[k] = mh[k-1];
            mh[0] = b;
            for (int k = 0; k < 10; k++) exp_win[n][k*8 +: 8] = mh[k];
            exp_v[n] = (base + n + 1) >= WINB;
            n++;
         end
      end
      mcnt = (base + n >= WINB) ? WINB : base + n;
   endtask

   task automatic write_row(input int row, input logic [WIN_W-1:0] m);
      @(negedge clk);
      cfg_wr_en = 1'b1;
      cfg_wr_row = ROW_AW'(row);
      cfg_wr_mask = m;
      @(posedge clk);
      @(negedge clk);
      cfg_wr_en = 1'b0;
      if (row < HASH_W) mmask[row] = m;
   endtask

   task automatic check_lanes(input string tag, input logic [3:0] tbl_mask);
      chk({tag, " R4 R5 out_valid"}, WIN_W'(out_valid), WIN_W'(tbl_mask));
      for (int j = 0; j < LANES; j++) begin
         if (exp_v[j]) begin
            chk({tag, " R3 window"}, out_win[j*WIN_W +: WIN_W], exp_win[j]);
            chk({tag, " R6 hash"}, WIN_W'(out_hash[j*HASH_W +: HASH_W]), WIN_W'(ref_hash(exp_win[j])));
         end
      end
   endtask

   // Drive one word, idle, and sample after the third edge (R7).
   task automatic step_word(input string tag, input logic v, input logic sop,
                            input logic [31:0] d, input logic [3:0] tbl_mask);
      @(negedge clk);
      in_valid = v;
      in_sop = sop;
      in_data = d;
      model_word(v, sop, d);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      in_sop = 1'b0;
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      check_lanes(tag, tbl_mask);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_fails++;
         $display("FAIL R7 watchdog actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

   initial begin : main
      logic [WIN_W-1:0] old0;
      logic [WIN_W-1:0] new0;
      for (int k = 0; k < 10; k++) mh[k] = '0;
      for (int i = 0; i < HASH_W; i++) mmask[i] = '0;
      exp_v = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset out_valid", WIN_W'(out_valid), '0);
      chk("R1 reset out_hash", WIN_W'(out_hash), '0);

      // Rows 6..11 stay zero so those hash bits must read 0 (R1).
      for (int i = 0; i < 6; i++) write_row(i, key_row(i));

      for (int t = 0; t < NVEC; t++)
         step_word($sformatf("vec%0d", t), TBL[t].v, TBL[t].sop, TBL[t].d, TBL[t].m);

      for (int i = 6; i < HASH_W; i++) write_row(i, key_row(i));

      // R7 and R8: write on the edge that registers the outputs -> old row.
      old0 = mmask[0];
      new0 = old0 ^ {{(WIN_W-1){1'b0}}, 1'b1};
      @(negedge clk);
      in_valid = 1'b1;
      in_data = 32'h41727170;
      model_word(1'b1, 1'b0, 32'h41727170);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      chk("R7 no output after one edge", WIN_W'(out_valid), '0);
      @(posedge clk);
      @(negedge clk);
      chk("R7 no output after two edges", WIN_W'(out_valid), '0);
      cfg_wr_en = 1'b1;
      cfg_wr_row = '0;
      cfg_wr_mask = new0;
      @(posedge clk);
      @(negedge clk);
      cfg_wr_en = 1'b0;
      chk("R7 output after three edges", WIN_W'(out_valid), WIN_W'(4'hF));
      chk("R8 late write uses old row", WIN_W'(out_hash[3*HASH_W]), WIN_W'(^(old0 & exp_win[3])));
      chk("R8 late write window", out_win[3*WIN_W +: WIN_W], exp_win[3]);
      mmask[0] = new0;

      // R8: write one edge earlier -> the new row is used.
      new0 = new0 ^ {{(WIN_W-1){1'b0}}, 1'b1};
      @(negedge clk);
      in_valid = 1'b1;
      in_data = 32'h41727170;
      model_word(1'b1, 1'b0, 32'h41727170);
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      cfg_wr_en = 1'b1;
      cfg_wr_row = '0;
      cfg_wr_mask = new0;
      @(posedge clk);
      @(negedge clk);
      cfg_wr_en = 1'b0;
      mmask[0] = new0;
      @(posedge clk);
      @(negedge clk);
      chk("R8 early write uses new row", WIN_W'(out_hash[3*HASH_W]), WIN_W'(^(new0 & exp_win[3])));
      check_lanes("R8 full", 4'hF);

      // R9: row 12 does not exist; every row must keep its key.
      write_row(12, {WIN_W{1'b1}});
      write_row(15, {WIN_W{1'b1}});
      step_word("R9 phantom rows", 1'b1, 1'b0, 32'h54535251, 4'hF);

      // R10 again: idle word carrying bytes, then a word that shows the history.
      step_word("R10 idle", 1'b0, 1'b0, 32'h39383736, 4'h0);
      step_word("R10 after idle", 1'b1, 1'b0, 32'h09303132, 4'h7);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end
endmodule